// File: doc/BRIEF.md
# Single-Region Memory Protection Checker

This block guards one window of the address space. Software programs a 32-bit configuration word through a small write port. The word holds the region's size exponent, an enable bit, eight subregion-off bits, an execute-never flag and a set of raw permission and memory-type fields. The port can write the whole word, or only its upper half or only its lower half.

A separate input gives the region's base address. Every cycle the checker looks at the presented access address and a flag that marks instruction fetches. It reports whether the address falls inside an active part of the region, and whether the access is a fetch that execute-never forbids. The checking logic is combinational. The permission and memory-type fields go out unchanged, so that a later stage can interpret them.

A parent unit builds multi-region protection by placing several of these blocks side by side and resolving their hits by priority.

Top module: `region_guard`

## Requirements
- R1: After reset the configuration word reads 0x00000000 and `hit` and `xnViolation` are 0.
- R2: Readback puts the fields at fixed positions: execute-never at bit 28, permission at 26:24, type extension at 21:19, shareable at 18, cacheable at 17, bufferable at 16, subregion-off at 15:8, size exponent at 5:1 and enable at bit 0. All other bits read 0, so writing 0xFFFFFFFF reads back 0x173FFF3F.
- R3: `wrLanes` bit 0 writes bits 15:0 from `wrData[15:0]`, and bit 1 writes bits 31:16 from `wrData[31:16]`. A half that is not selected keeps its value.
- R4: A size exponent below 4 that is written through the lower half is stored as 4.
- R5: With exponent S, the region covers 2^(S+1) bytes. An address matches when its bits from S+1 upward equal the same bits of `baseAddr`. The base bits below S+1 are ignored.
- R6: `hit` stays 0 whenever the enable bit is 0.
- R7: For S of 7 or more, the region splits into eight equal parts. Part k is picked by offset bits S:S-2. Subregion-off bit k set to 1 removes part k from the region, and 0 keeps it.
- R8: For S of 6 or less, the subregion-off field has no effect on `hit`.
- R9: `xnViolation` is 1 only when the access hits, `accIsFetch` is 1 and execute-never is 1.
- R10: `apField`, `texField`, `shareable`, `cacheable` and `bufferable` show the stored fields at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrLanes | input | 2 | Half select: bit 0 lower half, bit 1 upper half |
| wrData | input | 32 | Write data, each half in its own lane |
| rdData | output | 32 | Current configuration word |
| baseAddr | input | ADDR_W | Region base address |
| accAddr | input | ADDR_W | Address of the access being checked |
| accIsFetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| hit | output | 1 | Access falls in an enabled, active part of the region |
| xnViolation | output | 1 | Fetch that hits an execute-never region |
| apField | output | 3 | Stored access permission field |
| texField | output | 3 | Stored type-extension field |
| shareable | output | 1 | Stored shareable bit |
| cacheable | output | 1 | Stored cacheable bit |
| bufferable | output | 1 | Stored bufferable bit |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any write. They also assume that the access inputs are stable around each clock edge, because `hit` and `xnViolation` are sampled there even though they are combinational. The bench changes every input on the falling edge and holds it through the next rising edge. It applies reset before the first write, and it always sets `baseAddr` and `accAddr` before it samples the outputs.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  localparam int CFG_W    = 32;
  localparam int SIZE_W   = 5;
  localparam int SUB_N    = 8;
  localparam int SUB_IDXW = $clog2(SUB_N);

  localparam logic [SIZE_W-1:0] MIN_EXP = 5'd4;
  localparam logic [SIZE_W-1:0] SUB_MIN_EXP = 5'd7;

  localparam int XN_BIT   = 28;
  localparam int AP_LSB   = 24;
  localparam int TEX_LSB  = 19;
  localparam int SH_BIT   = 18;
  localparam int CA_BIT   = 17;
  localparam int BU_BIT   = 16;
  localparam int SRD_LSB  = 8;
  localparam int EXP_LSB  = 1;
  localparam int EN_BIT   = 0;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
  } regStrobe_t;

endpackage

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrLanes,
  output regStrobe_t strobe
);

  always_comb begin
    strobe.loadLo = wrEn & wrLanes[0];
    strobe.loadHi = wrEn & wrLanes[1];
  end

endmodule

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [CFG_W-1:0]  wrData,
  output logic [CFG_W-1:0]  rdData,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsFetch,
  output logic              hit,
  output logic              xnViolation,
  output logic [2:0]        apField,
  output logic [2:0]        texField,
  output logic              shareable,
  output logic              cacheable,
  output logic              bufferable
);

  logic              xnReg;
  logic [2:0]        apReg;
  logic [2:0]        texReg;
  logic              shReg;
  logic              caReg;
  logic              buReg;
  logic [SUB_N-1:0]  srdReg;
  logic [SIZE_W-1:0] expReg;
  logic              enReg;

  logic [SIZE_W-1:0] expIn;
  logic              unusedWrBits;

  assign unusedWrBits = ^{wrData[31:29], wrData[23:22], wrData[7:6]};
  assign expIn = (wrData[EXP_LSB +: SIZE_W] < MIN_EXP) ? MIN_EXP
                                                      : wrData[EXP_LSB +: SIZE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xnReg  <= 1'b0;
      apReg  <= '0;
      texReg <= '0;
      shReg  <= 1'b0;
      caReg  <= 1'b0;
      buReg  <= 1'b0;
      srdReg <= '0;
      expReg <= '0;
      enReg  <= 1'b0;
    end else begin
      if (strobe.loadHi) begin
        xnReg  <= wrData[XN_BIT];
        apReg  <= wrData[AP_LSB +: 3];
        texReg <= wrData[TEX_LSB +: 3];
        shReg  <= wrData[SH_BIT];
        caReg  <= wrData[CA_BIT];
        buReg  <= wrData[BU_BIT];
      end
      if (strobe.loadLo) begin
        srdReg <= wrData[SRD_LSB +: SUB_N];
        expReg <= expIn;
        enReg  <= wrData[EN_BIT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    rdData[XN_BIT]             = xnReg;
    rdData[AP_LSB +: 3]        = apReg;
    rdData[TEX_LSB +: 3]       = texReg;
    rdData[SH_BIT]             = shReg;
    rdData[CA_BIT]             = caReg;
    rdData[BU_BIT]             = buReg;
    rdData[SRD_LSB +: SUB_N]   = srdReg;
    rdData[EXP_LSB +: SIZE_W]  = expReg;
    rdData[EN_BIT]             = enReg;
  end

  // Per-bit compare mask: bits above the exponent must match the base.
  logic [ADDR_W-1:0] cmpMask;
  for (genvar g = 0; g < ADDR_W; g++) begin : gMask
    assign cmpMask[g] = (32'(g) > 32'(expReg));
  end

  logic              baseMatch;
  logic [SUB_IDXW-1:0] subIdx;
  logic              subOff;

  assign baseMatch = (((accAddr ^ baseAddr) & cmpMask) == '0);
  assign subIdx    = SUB_IDXW'(accAddr >> (expReg - 5'd2));
  assign subOff    = (expReg >= SUB_MIN_EXP) && srdReg[subIdx];

  assign hit         = enReg && baseMatch && !subOff;
  assign xnViolation = hit && accIsFetch && xnReg;

  assign apField    = apReg;
  assign texField   = texReg;
  assign shareable  = shReg;
  assign cacheable  = caReg;
  assign bufferable = buReg;

  assert_no_hit_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> !hit);

  assert_xn_needs_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    xnViolation |-> (hit && accIsFetch && rdData[XN_BIT]));

  assert_exp_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLo |=> (rdData[EXP_LSB +: SIZE_W] >= MIN_EXP));

  assert_lo_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadHi && !strobe.loadLo) |=> $stable(rdData[15:0]));

  assert_hi_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLo && !strobe.loadHi) |=> $stable(rdData[31:16]));

  assert_hit_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (((64'(accAddr) ^ 64'(baseAddr)) >> (32'(expReg) + 1)) == 64'd0));

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrLanes,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsFetch,
  output logic              hit,
  output logic              xnViolation,
  output logic [2:0]        apField,
  output logic [2:0]        texField,
  output logic              shareable,
  output logic              cacheable,
  output logic              bufferable
);

  regStrobe_t strobe;

  region_guard_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrLanes (wrLanes),
    .strobe  (strobe)
  );

  region_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .rdData      (rdData),
    .baseAddr    (baseAddr),
    .accAddr     (accAddr),
    .accIsFetch  (accIsFetch),
    .hit         (hit),
    .xnViolation (xnViolation),
    .apField     (apField),
    .texField    (texField),
    .shareable   (shareable),
    .cacheable   (cacheable),
    .bufferable  (bufferable)
  );

endmodule

// File: tb/test_region_guard.sv
module test_region_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  localparam logic [31:0] BASE = 32'h2000_0000;

  // config word, access address, fetch, expected hit, expected violation
  localparam logic [31:0] TV_CFG [NV] = '{
    32'h0000_0013, 32'h0000_0013, 32'h1000_0013, 32'h1000_0013,
    32'h1000_0012, 32'h0000_0413, 32'h0000_0413, 32'h0000_FF0D,
    32'h0000_FF0D, 32'h0000_0009, 32'h0000_0009, 32'h0000_003F,
    32'h0000_800F, 32'h0000_800F };
  localparam logic [31:0] TV_ADDR [NV] = '{
    32'h2000_03FC, 32'h2000_0400, 32'h2000_0010, 32'h2000_0010,
    32'h2000_0010, 32'h2000_0140, 32'h2000_01C0, 32'h2000_007F,
    32'h2000_0080, 32'h2000_001F, 32'h2000_0020, 32'hDEAD_BEEF,
    32'h2000_00E4, 32'h2000_00C4 };
  localparam bit TV_FETCH [NV] = '{0,0,1,0, 1,0,0,0, 0,0,0,1, 0,0};
  localparam bit TV_HIT   [NV] = '{1,0,1,1, 0,0,1,1, 0,1,0,1, 0,1};
  localparam bit TV_XN    [NV] = '{0,0,1,0, 0,0,0,0, 0,0,0,0, 0,0};
  localparam string TV_REQ [NV] = '{
    "R5","R5","R9","R9","R6","R7","R7","R8","R8","R5","R5","R5","R7","R7" };

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrLanes;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [31:0] baseAddr;
  logic [31:0] accAddr;
  logic        accIsFetch;
  logic        hit;
  logic        xnViolation;
  logic [2:0]  apField;
  logic [2:0]  texField;
  logic        shareable;
  logic        cacheable;
  logic        bufferable;

  int nRun  = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_guard #(.ADDR_W(32)) i_region_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLanes(wrLanes), .wrData(wrData),
    .rdData(rdData), .baseAddr(baseAddr), .accAddr(accAddr),
    .accIsFetch(accIsFetch), .hit(hit), .xnViolation(xnViolation),
    .apField(apField), .texField(texField), .shareable(shareable),
    .cacheable(cacheable), .bufferable(bufferable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [1:0] lanes, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrLanes = lanes; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrLanes = 2'b00; wrData = '0;
  endtask

  task automatic probe(input logic [31:0] addr, input logic fetch);
    accAddr = addr; accIsFetch = fetch;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrLanes = 2'b00; wrData = '0;
    baseAddr = BASE; accAddr = BASE; accIsFetch = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 hit", {31'b0, hit}, 32'h0);
    check("R1 xn", {31'b0, xnViolation}, 32'h0);

    // Table walk: full-word configuration then one probe each
    for (int i = 0; i < NV; i++) begin
      writeCfg(2'b11, TV_CFG[i]);
      baseAddr = BASE;
      probe(TV_ADDR[i], TV_FETCH[i]);
      check({TV_REQ[i], " hit"}, {31'b0, hit}, {31'b0, TV_HIT[i]});
      check({TV_REQ[i], " xn"},  {31'b0, xnViolation}, {31'b0, TV_XN[i]});
    end

    // R2: reserved bits read zero
    writeCfg(2'b11, 32'hFFFF_FFFF);
    #1;
    check("R2 readback", rdData, 32'h173F_FF3F);
    // R10: attribute outputs
    check("R10 fields", {21'b0, apField, texField, shareable, cacheable, bufferable, 3'b0},
          {21'b0, 3'd7, 3'd7, 3'b111, 3'b0});

    // R3: lower half alone
    writeCfg(2'b01, 32'hFFFF_0009);
    #1;
    check("R3 lo only", rdData, 32'h173F_0009);
    // R3: upper half alone
    writeCfg(2'b10, 32'h0228_FFFF);
    #1;
    check("R3 hi only", rdData, 32'h0228_0009);
    // R10: distinct field values
    check("R10 ap", {29'b0, apField}, 32'd2);
    check("R10 tex", {29'b0, texField}, 32'd5);
    check("R10 scb", {29'b0, shareable, cacheable, bufferable}, 32'd0);

    // R4: exponent clamps
    writeCfg(2'b01, 32'h0000_0003);
    #1;
    check("R4 exp1", rdData, 32'h0228_0009);
    writeCfg(2'b01, 32'h0000_0001);
    #1;
    check("R4 exp0", rdData, 32'h0228_0009);
    // R4: clamped region is 32 bytes
    probe(32'h2000_001F, 1'b0);
    check("R4 in32", {31'b0, hit}, 32'd1);
    probe(32'h2000_0020, 1'b0);
    check("R4 out32", {31'b0, hit}, 32'd0);

    // R5: unaligned base, low bits ignored (256-byte region)
    writeCfg(2'b11, 32'h0000_000F);
    baseAddr = 32'h4000_00A7;
    probe(32'h4000_0003, 1'b0);
    check("R5 unaligned base", {31'b0, hit}, 32'd1);
    probe(32'h4000_0100, 1'b0);
    check("R5 above window", {31'b0, hit}, 32'd0);

    // R7: every subregion off except part 0 (512-byte region)
    writeCfg(2'b11, 32'h0000_FE11);
    baseAddr = 32'h0000_0000;
    probe(32'h0000_003F, 1'b0);
    check("R7 part0", {31'b0, hit}, 32'd1);
    probe(32'h0000_0040, 1'b0);
    check("R7 part1", {31'b0, hit}, 32'd0);
    probe(32'h0000_01FF, 1'b0);
    check("R7 part7", {31'b0, hit}, 32'd0);

    // R9: execute-never fetch vs miss
    writeCfg(2'b10, 32'h1000_0000);
    probe(32'h0000_0010, 1'b1);
    check("R9 xn fetch", {31'b0, xnViolation}, 32'd1);
    probe(32'h0000_0100, 1'b1);
    check("R9 xn miss", {31'b0, xnViolation}, 32'd0);

    // R1: reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    probe(32'h0000_0010, 1'b1);
    check("R1 rerst rd", rdData, 32'h0);
    check("R1 rerst hit", {31'b0, hit}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule